// File: doc/BRIEF.md
# Almost-Flag Offset Programming Controller

This controller supplies the two threshold offsets that a 1024-word FIFO compares against its fill level: an almost-empty offset (X) and an almost-full offset (Y). The offset source is chosen by a two-bit mode input that is captured during reset. There are four modes. Two are fixed presets, one takes the offsets from the first two accepted writes on the data port, and one shifts them in as a 20-bit serial stream.

The controller drives a write-ready gate that the FIFO's input-ready flag must follow. While programming is still pending, the gate holds writes off. In the data-port mode it also diverts the two configuration writes, so that they never reach FIFO memory. The controller clamps any programmed offset outside the legal window to the nearest limit and raises a sticky error output. The FIFO storage and its flags are not part of this block.

Top module: `offset_prog_ctrl`

## Requirements
- R1: `mode_sel` is sampled on every clock edge while `rst` is high. The value captured at the last reset edge selects the mode until the next reset: 2'b00 data port, 2'b01 preset 8, 2'b10 preset 64, 2'b11 serial. Changes to `mode_sel` after release have no effect.
- R2: In either preset mode, `x_off` and `y_off` both equal the preset (8 for 2'b01, 64 for 2'b10) from release onward. No further setup is needed.
- R3: In preset and data-port modes, `wr_ready` is low after the first clock edge following reset release and high after the second.
- R4: In data-port mode, the first accepted write (`wr_req` high while `wr_ready` is high) loads `y_off` from `wr_data_lo`, and the second loads `x_off`. Bit 9 is the MSB. Until loaded, each offset reads 1.
- R5: `fifo_wr` is high only for an accepted write that is not a configuration write. The two data-port configuration writes, and any `wr_req` while `wr_ready` is low, produce no `fifo_wr` and load nothing.
- R6: In serial mode, each clock edge with `ser_en_n` low shifts in `ser_bit`, and edges with `ser_en_n` high shift nothing. The first of the 20 bits is the MSB of Y. Bits 1 to 10 form Y MSB-first, and bits 11 to 20 form X MSB-first, so the last bit is the LSB of X.
- R7: In serial mode, `wr_ready` stays low through the edge that takes the 20th bit. It rises on the following edge, together with the new `x_off` and `y_off`.
- R8: A programmed offset of 0 becomes 1, and a programmed offset above 1020 becomes 1020.
- R9: `range_err` is low in reset. It goes high when a programmed offset was clamped, and it stays high until the next reset.
- R10: Once programming completes, further serial bits and writes leave `x_off` and `y_off` unchanged until the next reset.
- R11: While `rst` is high, `wr_ready`, `fifo_wr` and `range_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Offset source select, captured during reset |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| wr_req | input | 1 | Write request from the data port |
| wr_data_lo | input | 10 | Low bits of the write data word |
| wr_ready | output | 1 | Write readiness gate for the FIFO input-ready flag |
| fifo_wr | output | 1 | Write strobe forwarded to FIFO memory |
| x_off | output | 10 | Almost-empty offset |
| y_off | output | 10 | Almost-full offset |
| range_err | output | 1 | Sticky flag: a programmed offset was clamped |

## Verification
The hardest case to reach is the exact cycle at which a serial load finishes. Readiness must stay low on the edge that takes the 20th bit, even after the stream has paused mid-way with the enable high and junk on the data pin, and must then rise one edge later. The stimulus inserts such a pause and then samples readiness and both offsets on each side of that boundary. A second hard case is a write request held high across the two start-up edges in data-port mode. That request must neither consume the Y slot nor reach memory, and the bench shows this by checking that the later configuration writes still land in Y and then X.

// File: rtl/offset_prog_pkg.sv
package offset_prog_pkg;

  // Offset source, encoded as the two mode bits seen at reset release.
  typedef enum logic [1:0] {
    SRC_PORT      = 2'b00,
    SRC_PRESET_LO = 2'b01,
    SRC_PRESET_HI = 2'b10,
    SRC_SERIAL    = 2'b11
  } ofs_src_e;

endpackage

// File: rtl/offset_clamp.sv
module offset_clamp #(
  parameter int OFF_W   = 10,
  parameter int MIN_OFF = 1,
  parameter int MAX_OFF = 1020
) (
  input  logic [OFF_W-1:0] raw,
  output logic [OFF_W-1:0] fixed,
  output logic             bad
);

  localparam logic [OFF_W-1:0] LO = OFF_W'(MIN_OFF);
  localparam logic [OFF_W-1:0] HI = OFF_W'(MAX_OFF);

  always_comb begin
    if (raw < LO) begin
      fixed = LO;
      bad   = 1'b1;
    end else if (raw > HI) begin
      fixed = HI;
      bad   = 1'b1;
    end else begin
      fixed = raw;
      bad   = 1'b0;
    end
  end

endmodule

// File: rtl/offset_serial_shift.sv
module offset_serial_shift #(
  parameter int OFF_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [2*OFF_W-1:0]   chain,
  output logic                 full
);

  localparam int NB = 2 * OFF_W;
  localparam int CW = $clog2(NB + 1);

  logic [CW-1:0] cnt;

  assign full = (cnt == CW'(NB));

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      cnt   <= '0;
    end else if (shift_en && !full) begin
      chain <= {chain[NB-2:0], bit_in};
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/offset_prog_seq.sv
module offset_prog_seq
  import offset_prog_pkg::*;
#(
  parameter int STARTUP = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  ofs_src_e mode_in,
  input  logic     wr_req,
  input  logic     ser_full,
  output ofs_src_e mode_q,
  output logic     ready_q,
  output logic     done_q,
  output logic     take_y,
  output logic     take_x,
  output logic     ser_commit,
  output logic     ser_allow,
  output logic     fifo_wr
);

  localparam int SCW = $clog2(STARTUP + 1);

  logic [SCW-1:0] start_cnt;
  logic [1:0]     pcnt;
  logic           accept;
  logic           cfg_phase;
  logic           start_warm;

  assign accept     = wr_req && ready_q;
  assign cfg_phase  = (mode_q == SRC_PORT) && (pcnt != 2'd2);
  assign take_y     = accept && cfg_phase && (pcnt == 2'd0);
  assign take_x     = accept && cfg_phase && (pcnt == 2'd1);
  assign fifo_wr    = accept && !cfg_phase;
  assign ser_allow  = (mode_q == SRC_SERIAL) && !done_q;
  assign ser_commit = ser_allow && ser_full;
  assign start_warm = (start_cnt == SCW'(STARTUP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= mode_in;
      start_cnt <= '0;
      ready_q   <= 1'b0;
      done_q    <= 1'b0;
      pcnt      <= 2'd0;
    end else begin
      if (start_cnt != SCW'(STARTUP))
        start_cnt <= start_cnt + 1'b1;
      unique case (mode_q)
        SRC_PRESET_LO, SRC_PRESET_HI: begin
          if (start_warm) begin
            ready_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end
        SRC_PORT: begin
          if (start_warm)
            ready_q <= 1'b1;
          if (take_y)
            pcnt <= 2'd1;
          if (take_x) begin
            pcnt   <= 2'd2;
            done_q <= 1'b1;
          end
        end
        SRC_SERIAL: begin
          if (ser_commit) begin
            ready_q <= 1'b1;
            done_q  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/offset_prog_ctrl.sv
module offset_prog_ctrl
  import offset_prog_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int OFF_W     = $clog2(DEPTH),
  parameter int MIN_OFF   = 1,
  parameter int MAX_OFF   = DEPTH - 4,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 64,
  parameter int STARTUP   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             ser_en_n,
  input  logic             ser_bit,
  input  logic             wr_req,
  input  logic [OFF_W-1:0] wr_data_lo,
  output logic             wr_ready,
  output logic             fifo_wr,
  output logic [OFF_W-1:0] x_off,
  output logic [OFF_W-1:0] y_off,
  output logic             range_err
);

  localparam int NB = 2 * OFF_W;

  ofs_src_e          mode_in;
  ofs_src_e          seq_mode;
  logic              seq_done;
  logic              take_y;
  logic              take_x;
  logic              ser_commit;
  logic              ser_allow;
  logic              ser_full;
  logic [NB-1:0]     chain;
  logic [OFF_W-1:0]  raw   [2];
  logic [OFF_W-1:0]  fixed [2];
  logic              bad   [2];

  assign mode_in = ofs_src_e'(mode_sel);

  function automatic logic [OFF_W-1:0] reset_offset(input ofs_src_e m);
    case (m)
      SRC_PRESET_LO: reset_offset = OFF_W'(PRESET_LO);
      SRC_PRESET_HI: reset_offset = OFF_W'(PRESET_HI);
      default:       reset_offset = OFF_W'(MIN_OFF);
    endcase
  endfunction

  offset_prog_seq #(.STARTUP(STARTUP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode_in    (mode_in),
    .wr_req     (wr_req),
    .ser_full   (ser_full),
    .mode_q     (seq_mode),
    .ready_q    (wr_ready),
    .done_q     (seq_done),
    .take_y     (take_y),
    .take_x     (take_x),
    .ser_commit (ser_commit),
    .ser_allow  (ser_allow),
    .fifo_wr    (fifo_wr)
  );

  offset_serial_shift #(.OFF_W(OFF_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ser_allow && !ser_en_n),
    .bit_in   (ser_bit),
    .chain    (chain),
    .full     (ser_full)
  );

  // Index 0 carries X (low half of the chain), index 1 carries Y.
  assign raw[0] = (seq_mode == SRC_SERIAL) ? chain[OFF_W-1:0]  : wr_data_lo;
  assign raw[1] = (seq_mode == SRC_SERIAL) ? chain[NB-1:OFF_W] : wr_data_lo;

  for (genvar g = 0; g < 2; g++) begin : g_clamp
    offset_clamp #(.OFF_W(OFF_W), .MIN_OFF(MIN_OFF), .MAX_OFF(MAX_OFF)) u_clamp (
      .raw   (raw[g]),
      .fixed (fixed[g]),
      .bad   (bad[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_off     <= reset_offset(mode_in);
      y_off     <= reset_offset(mode_in);
      range_err <= 1'b0;
    end else begin
      if (ser_commit) begin
        x_off <= fixed[0];
        y_off <= fixed[1];
        if (bad[0] || bad[1])
          range_err <= 1'b1;
      end
      if (take_y) begin
        y_off <= fixed[1];
        if (bad[1])
          range_err <= 1'b1;
      end
      if (take_x) begin
        x_off <= fixed[0];
        if (bad[0])
          range_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/offset_prog_chk.sv
module offset_prog_chk #(
  parameter int OFF_W   = 10,
  parameter int MIN_OFF = 1,
  parameter int MAX_OFF = 1020
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_req,
  input logic             wr_ready,
  input logic             fifo_wr,
  input logic             done,
  input logic [1:0]       mode,
  input logic [OFF_W-1:0] x_off,
  input logic [OFF_W-1:0] y_off,
  input logic             range_err
);

  // R3: readiness never rises on the first edge after release
  assert_ready_late_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wr_ready);

  // R5: memory writes only for requested, ready cycles
  assert_fifo_wr_gated_R5: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (wr_req && wr_ready));

  // R7: serial mode keeps readiness low until programming finishes
  assert_serial_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !done) |-> !wr_ready);

  // R8: offsets stay inside the legal window
  assert_offset_window_R8: assert property (@(posedge clk) disable iff (rst)
    (x_off >= OFF_W'(MIN_OFF)) && (x_off <= OFF_W'(MAX_OFF)) &&
    (y_off >= OFF_W'(MIN_OFF)) && (y_off <= OFF_W'(MAX_OFF)));

  // R9: error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(range_err) |-> range_err);

  // R10: offsets frozen once programming is complete
  assert_offsets_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(x_off) && $stable(y_off)));

endmodule

bind offset_prog_ctrl offset_prog_chk #(
  .OFF_W(OFF_W), .MIN_OFF(MIN_OFF), .MAX_OFF(MAX_OFF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_req    (wr_req),
  .wr_ready  (wr_ready),
  .fifo_wr   (fifo_wr),
  .done      (seq_done),
  .mode      (seq_mode),
  .x_off     (x_off),
  .y_off     (y_off),
  .range_err (range_err)
);

// File: tb/offset_prog_ctrl_tb.sv
module offset_prog_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic       ser_en_n;
  logic       ser_bit;
  logic       wr_req;
  logic [9:0] wr_data_lo;
  logic       wr_ready;
  logic       fifo_wr;
  logic [9:0] x_off;
  logic [9:0] y_off;
  logic       range_err;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  offset_prog_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .ser_en_n   (ser_en_n),
    .ser_bit    (ser_bit),
    .wr_req     (wr_req),
    .wr_data_lo (wr_data_lo),
    .wr_ready   (wr_ready),
    .fifo_wr    (fifo_wr),
    .x_off      (x_off),
    .y_off      (y_off),
    .range_err  (range_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Holds pre for two reset edges, then m on the final one, then releases.
  task automatic do_reset(input logic [1:0] m, input logic [1:0] pre);
    rst = 1'b1; mode_sel = pre; wr_req = 1'b0; ser_en_n = 1'b1; ser_bit = 1'b0;
    tick();
    check("R11 ready in reset", wr_ready, 0);
    check("R11 fifo_wr in reset", fifo_wr, 0);
    check("R11 err in reset", range_err, 0);
    tick();
    mode_sel = m;
    tick();
    rst = 1'b0;
    mode_sel = ~m;
  endtask

  task automatic port_write(input int d, input int exp_fifo_wr);
    wr_req = 1'b1; wr_data_lo = 10'(d);
    #1 check("R5 fifo_wr on write", fifo_wr, exp_fifo_wr);
    tick();
    wr_req = 1'b0;
  endtask

  task automatic ser_send(input logic [19:0] v, input bit pause);
    for (int i = 19; i >= 0; i--) begin
      ser_en_n = 1'b0; ser_bit = v[i];
      tick();
      if (pause && i == 12) begin
        ser_en_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
          ser_bit = k[0];
          tick();
        end
      end
    end
    ser_en_n = 1'b1;
  endtask

  task automatic test_preset(input logic [1:0] m, input int val);
    do_reset(m, m);
    tick();
    check("R3 ready low after first edge", wr_ready, 0);
    tick();
    check("R3 ready high after second edge", wr_ready, 1);
    check("R2 x preset", x_off, val);
    check("R2 y preset", y_off, val);
    check("R9 no error on preset", range_err, 0);
  endtask

  task automatic test_mode_sample();
    do_reset(2'b01, 2'b11);
    mode_sel = 2'b10;
    tick(); tick();
    check("R1 last reset value selects preset 8 (x)", x_off, 8);
    check("R1 last reset value selects preset 8 (y)", y_off, 8);
    check("R1 ready as preset mode", wr_ready, 1);
  endtask

  task automatic test_port();
    do_reset(2'b00, 2'b00);
    wr_req = 1'b1; wr_data_lo = 10'd99;
    #1 check("R5 no fifo_wr before ready", fifo_wr, 0);
    tick();
    check("R3 ready low after first edge", wr_ready, 0);
    tick();
    wr_req = 1'b0;
    check("R3 ready high after second edge", wr_ready, 1);
    check("R5 early request not taken as Y", y_off, 1);
    port_write(300, 0);
    check("R4 first write loads y", y_off, 300);
    check("R4 x unloaded reads 1", x_off, 1);
    port_write(5, 0);
    check("R4 second write loads x", x_off, 5);
    check("R4 y kept", y_off, 300);
    port_write(77, 1);
    check("R10 x frozen after data write", x_off, 5);
    check("R10 y frozen after data write", y_off, 300);
    ser_send(20'hFFFFF, 1'b0);
    check("R10 serial ignored in port mode", x_off, 5);
    check("R9 no error", range_err, 0);
  endtask

  task automatic test_port_clamp();
    do_reset(2'b00, 2'b00);
    tick(); tick();
    port_write(0, 0);
    check("R8 y zero clamped to 1", y_off, 1);
    check("R9 err after y clamp", range_err, 1);
    port_write(1023, 0);
    check("R8 x clamped to 1020", x_off, 1020);
    check("R9 err stays", range_err, 1);
    do_reset(2'b10, 2'b10);
    check("R9 err cleared by reset", range_err, 0);
  endtask

  task automatic test_serial(input int yv, input int xv, input int ey, input int ex,
                             input int eerr, input bit pause);
    do_reset(2'b11, 2'b11);
    wr_req = 1'b1; wr_data_lo = 10'd3;
    #1 check("R5 no fifo_wr while serial pending", fifo_wr, 0);
    wr_req = 1'b0;
    ser_send({10'(yv), 10'(xv)}, pause);
    check("R7 ready low at last bit edge", wr_ready, 0);
    check("R7 x not yet updated", x_off, 1);
    tick();
    check("R7 ready high one edge later", wr_ready, 1);
    check("R6 y from first ten bits", y_off, ey);
    check("R6 x from last ten bits", x_off, ex);
    check("R9 serial error flag", range_err, eerr);
    port_write(12, 1);
    ser_send(20'h5A5A5, 1'b0);
    check("R10 y frozen after serial", y_off, ey);
    check("R10 x frozen after serial", x_off, ex);
  endtask

  initial begin
    rst = 1'b1; mode_sel = 2'b00; ser_en_n = 1'b1; ser_bit = 1'b0;
    wr_req = 1'b0; wr_data_lo = '0;
    @(negedge clk);
    test_preset(2'b01, 8);
    test_preset(2'b10, 64);
    test_mode_sample();
    test_port();
    test_port_clamp();
    test_serial(700, 33, 700, 33, 0, 1'b1);
    test_serial(1021, 0, 1020, 1, 1, 1'b0);
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule